// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block runs on the controller side of a two-wire serial memory bus. It brings the bus back to a known idle state after a protocol interruption, a power loss or a system reset. It never transfers data. On request it plays one fixed pattern on the clock and data lines:

1. A start condition.
2. Nine clock pulses with the data line released. These let any target that was stopped part-way through a byte shift out the rest of that byte and its acknowledge slot.
3. A second start condition.
4. A stop condition straight after the second start.

Both lines are open-drain. The block only pulls a line low or lets go of it. Its outputs are therefore pull-down enables (1 = pull low) and never a driven high level.

Timing is counted in quarter bit periods. A quarter lasts `div_i + 1` system clocks, and `div_i` is captured when a request is accepted. Each clock high phase and each clock low phase lasts two quarters. Data only moves in the middle of a clock low phase, which gives at least one quarter of setup and hold around each clock edge. In the middle of each of the nine dummy high phases the block reads the data line. If any of those reads is low, it reports a stuck-line status bit that stays valid after the sequence ends.

Top module: `bus_rcv_top`

## Requirements
- R1: After reset both pull-down enables are 0, and `busy_o`, `done_o` and `stuck_o` are 0. While `busy_o` is 0 neither line is pulled.
- R2: A one-cycle `start_i` while idle makes `busy_o` 1 from the next cycle. The first line activity is SDA pulled low while SCL stays released, which is a start condition.
- R3: The sequence lasts exactly 44 quarters, that is 44*(div+1) cycles with `busy_o` at 1, where div is the `div_i` value at acceptance.
- R4: SCL rises exactly ten times per sequence. The first nine rises are the dummy pulses. The tenth is the clock high phase that carries the second start and the stop.
- R5: Every SCL low phase, and every SCL high phase except the last, lasts 2*(div+1) cycles. SDA changes while SCL is low only at least div+1 cycles after the SCL fall. SCL rises only at least div+1 cycles after the last SDA change. SDA and SCL never change in the same cycle.
- R6: While SCL is released, SDA changes exactly three times, in this order: fall (first start), fall (second start), rise (stop). After the stop both lines stay released.
- R7: At the end `busy_o` drops and `done_o` is 1 for exactly one cycle, in the same cycle. Both lines are released in that cycle.
- R8: `start_i` while `busy_o` is 1 is ignored, and the running sequence keeps its length and shape.
- R9: Changing `div_i` while busy has no effect on the running sequence.
- R10: `stuck_o` becomes 1 exactly when `sda_i` reads 0 at the middle of one of the nine dummy high phases. A low level only while SCL is low, or only during the final high phase, leaves it 0. It holds while idle and clears when the next request is accepted.
- R11: An asynchronous reset asserted mid-sequence releases both lines and clears `busy_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a recovery sequence (taken only while idle) |
| div_i | input | DIV_W | Quarter-period length minus one, in system clocks |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| stuck_o | output | 1 | SDA read low during a dummy clock high phase |

## Verification
Sequences run at several divider values, including the one-clock quarter. This separates an off-by-one in the quarter counter from an error in the quarter pattern, because phase lengths and the total busy time both scale with the divider.

The data line model is run in four ways:
- It follows the block's own drive, which must give a clear status.
- It holds low during one chosen dummy high phase, which must set the status.
- It holds low only during clock low phases, which must not set the status.
- It holds low during the final high phase, which must not set the status.

These four cases pin down where the sample point sits.

Further runs add an extra request mid-sequence, a divider change mid-sequence and a reset mid-sequence. These show that the captured divider and the idle-only acceptance hold, and that the reset takes effect at once.

// File: rtl/bus_rcv_pkg.sv
package bus_rcv_pkg;

    // Line activity for one quarter of a bit period.
    typedef struct packed {
        logic scl_low;   // pull SCL low
        logic sda_low;   // pull SDA low
        logic sample;    // read SDA at the end of this quarter
    } bus_pat_t;

    // Quarters: 4 for the opening start, 4 per dummy clock, 4 for start+stop.
    function automatic int total_quarters(input int n_dummy);
        return 8 + 4 * n_dummy;
    endfunction

    // Line pattern for quarter index q of the recovery sequence.
    function automatic bus_pat_t pat_at(input int q, input int n_dummy);
        bus_pat_t p;
        int r;
        p = '0;
        if (q < 4) begin
            // released, start (SDA low under SCL high), SCL low, SDA released
            p.scl_low = (q >= 2);
            p.sda_low = (q == 1) || (q == 2);
        end else if (q < 4 + 4 * n_dummy) begin
            // two quarters high, two low, SDA released; read mid-high
            r = (q - 4) % 4;
            p.scl_low = (r >= 2);
            p.sample  = (r == 0);
        end else begin
            // SCL high throughout: released, start, hold, stop
            r = q - 4 - 4 * n_dummy;
            p.sda_low = (r == 1) || (r == 2);
        end
        return p;
    endfunction

endpackage

// File: rtl/bus_rcv_tick.sv
module bus_rcv_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        cnt_d  = cnt_q;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bus_rcv_seq.sv
module bus_rcv_seq
    import bus_rcv_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int N_DUMMY = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             tick_i,
    output logic             busy_o,
    output logic [DIV_W-1:0] div_o,
    output logic             accept_o,
    output logic             sample_o,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             done_o
);

    localparam int TOTAL_Q = total_quarters(N_DUMMY);
    localparam int Q_W     = $clog2(TOTAL_Q);

    typedef struct packed {
        logic             busy;
        logic [Q_W-1:0]   qidx;
        logic [DIV_W-1:0] div;
        logic             scl_oe;
        logic             sda_oe;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    bus_pat_t   cur_pat, nxt_pat;

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        cur_pat  = pat_at(int'(st_q.qidx), N_DUMMY);
        nxt_pat  = pat_at(int'(st_q.qidx) + 1, N_DUMMY);
        accept_o = !st_q.busy && start_i;
        sample_o = st_q.busy && tick_i && cur_pat.sample;

        if (accept_o) begin
            st_d.busy   = 1'b1;
            st_d.qidx   = '0;
            st_d.div    = div_i;
            st_d.scl_oe = 1'b0;
            st_d.sda_oe = 1'b0;
        end else if (st_q.busy && tick_i) begin
            if (int'(st_q.qidx) == TOTAL_Q - 1) begin
                st_d.busy   = 1'b0;
                st_d.qidx   = '0;
                st_d.scl_oe = 1'b0;
                st_d.sda_oe = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.qidx   = st_q.qidx + 1'b1;
                st_d.scl_oe = nxt_pat.scl_low;
                st_d.sda_oe = nxt_pat.sda_low;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign div_o    = st_q.div;
    assign scl_oe_o = st_q.scl_oe;
    assign sda_oe_o = st_q.sda_oe;
    assign done_o   = st_q.done;

endmodule

// File: rtl/bus_rcv_stuck.sv
module bus_rcv_stuck (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic sample_i,
    input  logic sda_i,
    output logic stuck_o
);

    logic stuck_d, stuck_q;

    always_comb begin
        stuck_d = stuck_q;
        if (clear_i) begin
            stuck_d = 1'b0;
        end else if (sample_i && !sda_i) begin
            stuck_d = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stuck_q <= 1'b0;
        end else begin
            stuck_q <= stuck_d;
        end
    end

    assign stuck_o = stuck_q;

endmodule

// File: rtl/bus_rcv_top.sv
module bus_rcv_top #(
    parameter int DIV_W   = 8,
    parameter int N_DUMMY = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             stuck_o
);

    logic             tick;
    logic             accept;
    logic             sample;
    logic [DIV_W-1:0] div_held;

    bus_rcv_tick #(.DIV_W(DIV_W)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (busy_o),
        .div_i  (div_held),
        .tick_o (tick)
    );

    bus_rcv_seq #(.DIV_W(DIV_W), .N_DUMMY(N_DUMMY)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .div_i    (div_i),
        .tick_i   (tick),
        .busy_o   (busy_o),
        .div_o    (div_held),
        .accept_o (accept),
        .sample_o (sample),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o),
        .done_o   (done_o)
    );

    bus_rcv_stuck u_stuck (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (accept),
        .sample_i (sample),
        .sda_i    (sda_i),
        .stuck_o  (stuck_o)
    );

endmodule

// File: rtl/bus_rcv_chk.sv
module bus_rcv_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic stuck_o
);

    // R1
    idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

    // R2
    start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    // R5
    no_joint_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sda_oe_o) |-> $stable(scl_oe_o));

    // R6
    stop_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(sda_oe_o) && !scl_oe_o) |=> (!scl_oe_o && !sda_oe_o));

    // R7
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($fell(busy_o) && !scl_oe_o && !sda_oe_o));

    // R10
    stuck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> $stable(stuck_o));

    // R10
    stuck_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stuck_o) |-> busy_o);

endmodule

bind bus_rcv_top bus_rcv_chk u_chk (.*);

// File: tb/bus_rcv_top_tb.sv
module bus_rcv_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic             pull = 1'b0;
    logic             sda_line;
    logic             scl_oe, sda_oe, busy, done, stuck;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    assign sda_line = !sda_oe && !pull;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_rcv_top #(.DIV_W(DIV_W), .N_DUMMY(9)) u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .div_i    (div),
        .sda_i    (sda_line),
        .scl_oe_o (scl_oe),
        .sda_oe_o (sda_oe),
        .busy_o   (busy),
        .done_o   (done),
        .stuck_o  (stuck)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int exp_cycles(input int d);
        return 44 * (d + 1);
    endfunction

    function automatic int exp_stuck(input int mode, input int k);
        return (mode == 1 && k >= 1 && k <= 9) ? 1 : 0;
    endfunction

    // mode 0: line follows drive; 1: low during high phase after rise k;
    // 2: low while SCL low inside the dummy clocks
    task automatic run_seq(input int d, input int mode, input int k,
                           input bit mid_start, input bit mid_div);
        int q, t, rises, ev_n, phase_bad, tim_bad;
        int last_scl_t, last_sda_t, phase_t;
        int ev[8];
        bit prev_sh, prev_dh, sh, dh;
        q = d + 1;
        @(negedge clk);
        div = DIV_W'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accepted start", int'(busy), 1);
        check(!scl_oe && !sda_oe, "R2 lines released in first quarter", int'({scl_oe, sda_oe}), 0);
        t = 0; rises = 0; ev_n = 0; phase_bad = 0; tim_bad = 0;
        last_scl_t = -1000; last_sda_t = -1000; phase_t = 0;
        prev_sh = 1'b1; prev_dh = 1'b1;
        while (busy && t < 5000) begin
            sh = !scl_oe;
            dh = !sda_oe;
            if (sh != prev_sh) begin
                if (t - phase_t != 2 * q) phase_bad++;
                if (sh) begin
                    rises++;
                    if (t - last_sda_t < q) tim_bad++;
                end
                last_scl_t = t;
                phase_t = t;
            end
            if (dh != prev_dh) begin
                if (sh) begin
                    if (prev_sh != sh) tim_bad++;
                    if (ev_n < 8) ev[ev_n] = dh ? 1 : 0;
                    ev_n++;
                end else if (t - last_scl_t < q) begin
                    tim_bad++;
                end
                last_sda_t = t;
            end
            case (mode)
                1: pull = sh && (rises == k);
                2: pull = !sh && rises >= 1 && rises <= 9;
                default: pull = 1'b0;
            endcase
            if (mid_start && t == 5 * q) start = 1'b1;
            if (mid_div && t == 3) div = DIV_W'(d + 3);
            prev_sh = sh;
            prev_dh = dh;
            @(negedge clk);
            start = 1'b0;
            t++;
        end
        pull = 1'b0;
        check(t == exp_cycles(d), "R3 busy length (R8 R9 when disturbed)", t, exp_cycles(d));
        check(rises == 10, "R4 SCL rise count", rises, 10);
        check(phase_bad == 0, "R5 SCL phase lengths", phase_bad, 0);
        check(tim_bad == 0, "R5 SDA setup and hold", tim_bad, 0);
        check(ev_n == 3 && ev[0] == 0 && ev[1] == 0 && ev[2] == 1,
              "R6 start start stop order", ev_n, 3);
        check(done == 1'b1 && !busy, "R7 done with busy low", int'({done, busy}), 2);
        check(!scl_oe && !sda_oe, "R7 lines released at end", int'({scl_oe, sda_oe}), 0);
        check(int'(stuck) == exp_stuck(mode, k), "R10 stuck status", int'(stuck), exp_stuck(mode, k));
        @(negedge clk);
        check(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
        check(int'(stuck) == exp_stuck(mode, k), "R10 stuck held when idle", int'(stuck), exp_stuck(mode, k));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_oe && !sda_oe && !busy && !done && !stuck, "R1 reset state",
              int'({scl_oe, sda_oe, busy, done, stuck}), 0);

        run_seq(0, 0, 0, 1'b0, 1'b0);
        run_seq(3, 1, 1, 1'b0, 1'b0);
        run_seq(1, 0, 0, 1'b0, 1'b0);   // R10 clear on new start
        run_seq(1, 1, 9, 1'b0, 1'b0);
        run_seq(2, 1, 10, 1'b0, 1'b0);  // R10 final high not sampled
        run_seq(1, 2, 0, 1'b0, 1'b0);   // R10 low only while SCL low
        run_seq(2, 0, 0, 1'b1, 1'b0);   // R8
        run_seq(1, 0, 0, 1'b0, 1'b1);   // R9
        div = '0;

        for (int i = 0; i < 14; i++) begin
            int d, m, k;
            d = int'($urandom % 5);
            m = int'($urandom % 3);
            k = 1 + int'($urandom % 10);
            run_seq(d, m, k, 1'($urandom % 2), 1'($urandom % 2));
            div = '0;
        end

        // R11 asynchronous reset mid-sequence
        @(negedge clk);
        div = 8'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(scl_oe || sda_oe || busy, "R11 sequence active before reset", 0, 1);
        #1 rst_n = 1'b0;
        #1;
        check(!scl_oe && !sda_oe && !busy, "R11 immediate release",
              int'({scl_oe, sda_oe, busy}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!scl_oe && !sda_oe && !busy && !done, "R11 idle after reset",
              int'({scl_oe, sda_oe, busy, done}), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule